// File: doc/BRIEF.md
# Committed-Rate Token Bucket Shaper

This block holds one committed-rate token bucket for each of a set of scheduling elements and turns the bucket levels into a per-element eligibility vector. An element's bucket fills whenever a frame charged to it is reported as sent. It drains only when an external leak pulse names that element. An element is cleared to send while its bucket is at or below its burst limit. The burst limit is programmed in units of 4096 bytes.

Each element has a rate, a burst and a frame mode, all written through a single write port. In data-rate mode a frame charges its own byte count. In line-rate mode a frame charges its byte count plus 20 bytes of preamble and inter-frame gap. An element whose rate and burst are both zero is unshaped and always eligible. The downstream scheduler reads the eligibility vector. Queueing and arbitration are left to that scheduler.

Top module: `cr_shaper`

## Requirements
- R1: After reset every element has rate 0, burst 0 and bucket level 0, and every bit of `eligible` is 1.
- R2: A config write (`cfg_we`=1) stores `cfg_rate`, `cfg_burst` and `cfg_mode` for element `cfg_idx` and clears its bucket level to 0. When a leak or a frame event names the same element in the same cycle, the write takes precedence and the level is still 0 afterwards.
- R3: An element with rate 0 and burst 0 is unshaped. It is always eligible, and frames sent on it do not charge its bucket.
- R4: In data-rate mode (`cfg_mode`=1), a frame event (`tx_vld`=1) adds `tx_len` bytes to the bucket of element `tx_idx`.
- R5: In line-rate mode (`cfg_mode`=0), a frame event adds `tx_len`+20 bytes to the bucket.
- R6: A leak event (`leak_vld`=1) subtracts rate × 2^RATE_UNIT_SHIFT bytes from the bucket of element `leak_idx`. With the default shift of 0 this is rate bytes. The level stops at 0 and never goes below it.
- R7: A shaped element is eligible exactly when its level is at or below burst × 4096 bytes. A level equal to the limit counts as eligible. Eligibility is registered: an event presented in one cycle shows on `eligible` in the next cycle.
- R8: When a frame and a leak name the same element in one cycle, the new level is max(0, level + charge − drain). The charge is added before the drain is taken off.
- R9: An event changes only the element it names. All other elements keep their level and eligibility.
- R10: The bucket level saturates at 2^LVL_W−1, which is 4194303 by default, and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_we | input | 1 | Config write strobe |
| cfg_idx | input | IDX_W | Element that the config write targets |
| cfg_rate | input | RATE_W | Committed rate in drain units per leak |
| cfg_burst | input | BURST_W | Burst limit in 4096-byte units |
| cfg_mode | input | 1 | Frame mode: 0 line-rate, 1 data-rate |
| leak_vld | input | 1 | Leak pulse |
| leak_idx | input | IDX_W | Element that the leak drains |
| tx_vld | input | 1 | Frame-sent event |
| tx_idx | input | IDX_W | Element that the frame is charged to |
| tx_len | input | LEN_W | Frame length in bytes |
| eligible | output | NUM_ELEM | Per-element send eligibility |

## Verification
Three functions can land in the same cycle on the same element: the frame charge, the leak drain and the config write. The bench provokes the charge and the drain together from a level of 0 with a charge larger than the burst limit. It judges the order by eligibility. Adding first leaves the element eligible, while draining first and then clamping leaves it ineligible. It also pairs a config write with a frame on the same element and then shows that the frame was not counted. Random traffic then mixes all three events at random indices, and each cycle the full vector is compared with a bench model.

// File: rtl/cr_shaper_pkg.sv
package cr_shaper_pkg;

  typedef enum logic {
    MODE_LINE = 1'b0,
    MODE_DATA = 1'b1
  } frame_mode_e;

  localparam int unsigned LINE_OVERHEAD_BYTES = 20;
  localparam int unsigned BURST_UNIT_SHIFT    = 12;

endpackage

// File: rtl/cr_shaper_charge.sv
module cr_shaper_charge
  import cr_shaper_pkg::*;
#(
  parameter int LEN_W = 14,
  localparam int CHG_W = LEN_W + 1
) (
  input  logic [LEN_W-1:0] tx_len,
  input  frame_mode_e      mode,
  output logic [CHG_W-1:0] charge
);

  logic [CHG_W-1:0] overhead;

  always_comb begin
    overhead = (mode == MODE_LINE) ? CHG_W'(LINE_OVERHEAD_BYTES) : '0;
    charge   = {1'b0, tx_len} + overhead;
  end

endmodule

// File: rtl/cr_shaper_elem.sv
module cr_shaper_elem
  import cr_shaper_pkg::*;
#(
  parameter int RATE_W          = 18,
  parameter int BURST_W         = 7,
  parameter int LEN_W           = 14,
  parameter int LVL_W           = 22,
  parameter int RATE_UNIT_SHIFT = 0,
  localparam int CHG_W = LEN_W + 1,
  localparam int SUM_W = LVL_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_hit,
  input  logic [RATE_W-1:0]  cfg_rate,
  input  logic [BURST_W-1:0] cfg_burst,
  input  frame_mode_e        cfg_mode,
  input  logic               leak_hit,
  input  logic               tx_hit,
  input  logic [LEN_W-1:0]   tx_len,
  output logic               eligible_o
);

  localparam logic [LVL_W-1:0] LVL_MAX = {LVL_W{1'b1}};

  logic [RATE_W-1:0]  rate_q,  rate_d;
  logic [BURST_W-1:0] burst_q, burst_d;
  frame_mode_e        mode_q,  mode_d;
  logic [LVL_W-1:0]   level_q, level_d;
  logic               elig_q,  elig_d;
  logic               upd_en;

  logic               off_q, off_d;
  logic [CHG_W-1:0]   charge;
  logic [SUM_W-1:0]   charge_eff;
  logic [SUM_W-1:0]   sum;
  logic [LVL_W-1:0]   sum_sat;
  logic [LVL_W-1:0]   drain;
  logic [LVL_W-1:0]   level_calc;
  logic [LVL_W-1:0]   limit_d;

  cr_shaper_charge #(.LEN_W(LEN_W)) charge_i (
    .tx_len (tx_len),
    .mode   (mode_q),
    .charge (charge)
  );

  always_comb begin
    off_q      = (rate_q == '0) && (burst_q == '0);
    charge_eff = (tx_hit && !off_q) ? SUM_W'(charge) : '0;
    drain      = leak_hit ? (LVL_W'(rate_q) << RATE_UNIT_SHIFT) : '0;
    sum        = SUM_W'(level_q) + charge_eff;
    sum_sat    = (sum > SUM_W'(LVL_MAX)) ? LVL_MAX : sum[LVL_W-1:0];
    level_calc = (sum_sat > drain) ? (sum_sat - drain) : '0;
  end

  always_comb begin
    upd_en  = cfg_hit | leak_hit | tx_hit;
    rate_d  = rate_q;
    burst_d = burst_q;
    mode_d  = mode_q;
    level_d = level_calc;
    if (cfg_hit) begin
      rate_d  = cfg_rate;
      burst_d = cfg_burst;
      mode_d  = cfg_mode;
      level_d = '0;
    end
    off_d   = (rate_d == '0) && (burst_d == '0);
    limit_d = LVL_W'(burst_d) << BURST_UNIT_SHIFT;
    elig_d  = off_d || (level_d <= limit_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q  <= '0;
      burst_q <= '0;
      mode_q  <= MODE_LINE;
      level_q <= '0;
      elig_q  <= 1'b1;
    end else if (upd_en) begin
      rate_q  <= rate_d;
      burst_q <= burst_d;
      mode_q  <= mode_d;
      level_q <= level_d;
      elig_q  <= elig_d;
    end
  end

  assign eligible_o = elig_q;

  // R2: a config write leaves an empty, eligible bucket
  assert_cfg_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_hit |=> (level_q == '0) && eligible_o);

  // R3: an unshaped element is always eligible
  assert_off_eligible_R3: assert property (@(posedge clk) disable iff (!rst_n)
    off_q |-> eligible_o);

  // R6: a leak alone never raises the level
  assert_leak_no_growth_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (leak_hit && !tx_hit && !cfg_hit) |=> (level_q <= $past(level_q)));

  // R4: a frame alone never lowers the level
  assert_frame_no_shrink_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_hit && !leak_hit && !cfg_hit) |=> (level_q >= $past(level_q)));

  // R9: an element not named holds its state
  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_hit && !leak_hit && !cfg_hit) |=> ($stable(level_q) && $stable(eligible_o)));

endmodule

// File: rtl/cr_shaper.sv
module cr_shaper
  import cr_shaper_pkg::*;
#(
  parameter int NUM_ELEM        = 8,
  parameter int RATE_W          = 18,
  parameter int BURST_W         = 7,
  parameter int LEN_W           = 14,
  parameter int LVL_W           = 22,
  parameter int RATE_UNIT_SHIFT = 0,
  localparam int IDX_W = (NUM_ELEM > 1) ? $clog2(NUM_ELEM) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [IDX_W-1:0]    cfg_idx,
  input  logic [RATE_W-1:0]   cfg_rate,
  input  logic [BURST_W-1:0]  cfg_burst,
  input  logic                cfg_mode,
  input  logic                leak_vld,
  input  logic [IDX_W-1:0]    leak_idx,
  input  logic                tx_vld,
  input  logic [IDX_W-1:0]    tx_idx,
  input  logic [LEN_W-1:0]    tx_len,
  output logic [NUM_ELEM-1:0] eligible
);

  logic [1:0]          rst_sync_q;
  logic                rst_int_n;
  logic [NUM_ELEM-1:0] cfg_hit, leak_hit, tx_hit;
  frame_mode_e         cfg_mode_e;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n  = rst_sync_q[1];
  assign cfg_mode_e = frame_mode_e'(cfg_mode);

  for (genvar g = 0; g < NUM_ELEM; g++) begin : g_elem
    always_comb begin
      cfg_hit[g]  = cfg_we   && (cfg_idx  == IDX_W'(g));
      leak_hit[g] = leak_vld && (leak_idx == IDX_W'(g));
      tx_hit[g]   = tx_vld   && (tx_idx   == IDX_W'(g));
    end

    cr_shaper_elem #(
      .RATE_W          (RATE_W),
      .BURST_W         (BURST_W),
      .LEN_W           (LEN_W),
      .LVL_W           (LVL_W),
      .RATE_UNIT_SHIFT (RATE_UNIT_SHIFT)
    ) elem_i (
      .clk        (clk),
      .rst_n      (rst_int_n),
      .cfg_hit    (cfg_hit[g]),
      .cfg_rate   (cfg_rate),
      .cfg_burst  (cfg_burst),
      .cfg_mode   (cfg_mode_e),
      .leak_hit   (leak_hit[g]),
      .tx_hit     (tx_hit[g]),
      .tx_len     (tx_len),
      .eligible_o (eligible[g])
    );
  end

  // R1: leaving reset, every element is eligible
  assert_reset_eligible_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_int_n) |-> (eligible == '1));

  // R9: one cycle of events changes at most two elements plus the configured one
  assert_event_scope_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    1'b1 |=> ($countones(eligible ^ $past(eligible)) <= 3));

endmodule

// File: tb/cr_shaper_tb_top.sv
module cr_shaper_tb_top;

  localparam int N      = 8;
  localparam int IDX_W  = 3;
  localparam int RATE_W = 18;
  localparam int BURST_W = 7;
  localparam int LEN_W  = 14;
  localparam longint LVL_MAX = (64'd1 << 22) - 1;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_we, cfg_mode, leak_vld, tx_vld;
  logic [IDX_W-1:0] cfg_idx, leak_idx, tx_idx;
  logic [RATE_W-1:0] cfg_rate;
  logic [BURST_W-1:0] cfg_burst;
  logic [LEN_W-1:0] tx_len;
  logic [N-1:0] eligible;

  longint m_rate[N], m_burst[N], m_level[N];
  bit m_mode[N];
  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  cr_shaper dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_rate(cfg_rate), .cfg_burst(cfg_burst), .cfg_mode(cfg_mode),
    .leak_vld(leak_vld), .leak_idx(leak_idx), .tx_vld(tx_vld),
    .tx_idx(tx_idx), .tx_len(tx_len), .eligible(eligible)
  );

  function automatic bit is_off(int i);
    return (m_rate[i] == 0) && (m_burst[i] == 0);
  endfunction

  function automatic logic [N-1:0] exp_elig();
    logic [N-1:0] v;
    for (int i = 0; i < N; i++)
      v[i] = is_off(i) || (m_level[i] <= m_burst[i] * 4096);
    return v;
  endfunction

  function automatic longint next_level(int i, bit txh, longint len, bit lkh);
    longint s, d;
    s = m_level[i];
    if (txh && !is_off(i)) s = s + len + (m_mode[i] ? 0 : 20);
    if (s > LVL_MAX) s = LVL_MAX;
    d = lkh ? m_rate[i] : 0;
    return (s > d) ? s - d : 0;
  endfunction

  task automatic model_update();
    for (int i = 0; i < N; i++) begin
      if (cfg_we && cfg_idx == IDX_W'(i)) begin
        m_rate[i] = cfg_rate; m_burst[i] = cfg_burst; m_mode[i] = cfg_mode;
        m_level[i] = 0;
      end else begin
        m_level[i] = next_level(i, tx_vld && tx_idx == IDX_W'(i), tx_len,
                                leak_vld && leak_idx == IDX_W'(i));
      end
    end
  endtask

  task automatic check(string tag);
    logic [N-1:0] e;
    e = exp_elig();
    tests++;
    if (eligible !== e) begin
      fails++;
      $display("FAIL %s eligible actual=%b expected=%b", tag, eligible, e);
    end
  endtask

  task automatic clear_in();
    cfg_we = 0; leak_vld = 0; tx_vld = 0;
    cfg_idx = 0; leak_idx = 0; tx_idx = 0;
    cfg_rate = 0; cfg_burst = 0; cfg_mode = 0; tx_len = 0;
  endtask

  task automatic tick(string tag);
    @(posedge clk);
    model_update();
    @(negedge clk);
    check(tag);
    clear_in();
  endtask

  task automatic cfg(int i, int r, int b, bit m);
    cfg_we = 1; cfg_idx = IDX_W'(i); cfg_rate = RATE_W'(r);
    cfg_burst = BURST_W'(b); cfg_mode = m;
  endtask

  task automatic frame(int i, int len);
    tx_vld = 1; tx_idx = IDX_W'(i); tx_len = LEN_W'(len);
  endtask

  task automatic leak(int i);
    leak_vld = 1; leak_idx = IDX_W'(i);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1 actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    clear_in();
    rst_n = 0;
    for (int i = 0; i < N; i++) begin
      m_rate[i] = 0; m_burst[i] = 0; m_level[i] = 0; m_mode[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R1 reset");

    // R4 data mode: 5000 bytes over a 4096-byte limit
    cfg(0, 10, 1, 1); tick("R2 cfg");
    frame(0, 5000);   tick("R4 data charge");
    cfg(0, 10, 1, 1); tick("R2 cfg clears level");

    // R5 line mode, R7 boundary, R6 leak
    cfg(1, 20, 1, 0); tick("R2 cfg");
    frame(1, 4076);   tick("R7 level equals limit");
    frame(1, 0);      tick("R5 line overhead");
    leak(1);          tick("R6 leak drains rate");

    // R6 floor at zero
    cfg(2, 1000, 1, 1); tick("R2 cfg");
    frame(2, 4000);     tick("R4 data charge");
    for (int k = 0; k < 5; k++) begin leak(2); tick("R6 floor"); end
    frame(2, 4096);     tick("R6 no negative level");

    // R8 charge then drain in one cycle
    cfg(3, 100, 1, 1); tick("R2 cfg");
    frame(3, 4150); leak(3); tick("R8 add before drain");
    frame(3, 50);   leak(3); tick("R8 combined");

    // R2 config wins over a frame in the same cycle
    cfg(4, 5, 1, 1); frame(4, 4096); tick("R2 cfg priority");
    frame(4, 4096);  tick("R2 frame not counted");

    // R3 unshaped element
    cfg(6, 0, 0, 1); tick("R2 cfg");
    frame(6, 16000); tick("R3 unshaped stays eligible");
    frame(6, 16000); tick("R3 unshaped stays eligible");

    // R9 others untouched while element 0 is hit
    frame(0, 100); leak(0); tick("R9 other elements");

    // R10 saturation
    cfg(5, 262143, 1, 1); tick("R2 cfg");
    for (int k = 0; k < 260; k++) begin frame(5, 16383); tick("R10 saturate"); end
    for (int k = 0; k < 16; k++) begin leak(5); tick("R10 drain from ceiling"); end

    // random mix
    void'($urandom(32'h5eed1234));
    for (int k = 0; k < 4000; k++) begin
      if ($urandom_range(0, 15) == 0) begin
        if ($urandom_range(0, 7) == 0)
          cfg($urandom_range(0, N-1), 0, 0, 1'($urandom_range(0, 1)));
        else
          cfg($urandom_range(0, N-1), $urandom_range(1, 3000),
              $urandom_range(0, 3), 1'($urandom_range(0, 1)));
      end
      if ($urandom_range(0, 2) == 0) leak($urandom_range(0, N-1));
      if ($urandom_range(0, 1) == 0) frame($urandom_range(0, N-1), $urandom_range(0, 9000));
      tick("R7 random");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule